// File: doc/BRIEF.md
# Bitstream Output Interface

This block drains a multiplexed audio/video byte stream to outside equipment. It takes bytes one at a time from an upstream source through a valid/ready pair. It delivers them through one of two ports, and a single control input chooses the port. The first is an 8-bit parallel port paced by a ready/acknowledge pair. This port takes its timing from an external clock of either polarity, or from a square wave the block generates itself. The second is a 16-bit host DMA port. That port moves a packed word either on a sampled DMA clock edge with an acknowledge, or on a chip-select/read-strobe exchange that needs no clock.

Every external timing input is oversampled in the block's own clock domain. The block counts the bytes moved in each handshake operation. When the per-operation limit is reached, it withholds its ready or request until the operation closes. In DMA mode, bytes are paired into words in a selectable byte order. A lone byte left over when the source runs dry, or when only one byte of the limit remains, goes out in a zero-padded word.

Top module: `av_stream_out`

## Requirements
- R1: `fmt_dma` = 0 routes the stream to the 8-bit port and holds `dma_req` and `dma_data` at 0. `fmt_dma` = 1 routes it to the DMA port and holds `sa_ready` and `sa_data` at 0.
- R2: In 8-bit mode, `sa_ready` is high exactly when `src_valid` is high and fewer than MAX_BYTES (2048) bytes have been moved since `sa_ack` was last seen low.
- R3: In 8-bit mode, one byte is moved on each active port clock edge seen while `sa_ready` and `sa_ack` are both high. `sa_data` carries the head byte with its most significant bit on `sa_data[7]`, and bytes leave in source order. Edges seen while `sa_ack` is low move nothing.
- R4: `sa_clk_mode` = 0 makes the rising edge of `sa_clk_in` active, and `sa_clk_mode` = 1 makes its falling edge active. Edges of the other polarity move nothing. With `sa_clk_mode[1]` = 1, `sa_clk_out` is a square wave with HALF_FAST (4) clock cycles per phase when `sa_clk_slow` = 0, or HALF_SLOW (8) when it is 1. The receiver samples on its rising edge. In the external modes, `sa_clk_out` stays low.
- R5: Once MAX_BYTES bytes have moved in one handshake operation, `sa_ready` or `dma_req` stays low until the operation closes. An operation closes when `sa_ack` goes low (8-bit port), `dma_ack` goes low (clocked DMA) or `host_cs_n` goes high (strobed DMA). After it closes, the count restarts from zero.
- R6: With `dma_two_cycle` = 0, one word moves on each rising edge of `dma_clk_in` seen while `dma_ack` and `dma_req` are high.
- R7: With `dma_two_cycle` = 1, one word moves on each rising edge of `host_rd_n` seen while `host_cs_n` is low and `dma_req` is high. Edges on `dma_clk_in` move nothing in this mode.
- R8: With `dma_big_endian` = 1, the earlier byte of a word is on `dma_data[15:8]`. With 0, it is on `dma_data[7:0]`. A word stays unchanged while `dma_req` is held.
- R9: A single pending byte is sent as a word whose other half is zero when the source is empty or only one byte of the limit remains. Such a word counts as one byte.
- R10: During and right after reset, `sa_ready`, `dma_req`, `src_ready` and `sa_clk_out` are low and `dma_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| fmt_dma | input | 1 | 0: 8-bit port, 1: 16-bit DMA port |
| sa_clk_mode | input | 2 | 0 rising ext, 1 falling ext, 2/3 internal clock |
| sa_clk_slow | input | 1 | Internal clock rate select |
| dma_two_cycle | input | 1 | 0 clocked DMA, 1 strobed DMA |
| dma_big_endian | input | 1 | Byte order of DMA words |
| src_valid | input | 1 | Source has a byte |
| src_data | input | 8 | Source head byte |
| src_ready | output | 1 | Byte taken from source this cycle |
| sa_clk_in | input | 1 | External port clock |
| sa_clk_out | output | 1 | Generated port clock |
| sa_data | output | 8 | 8-bit port data |
| sa_ready | output | 1 | 8-bit port has data |
| sa_ack | input | 1 | 8-bit port acknowledge / operation window |
| dma_clk_in | input | 1 | DMA clock |
| dma_req | output | 1 | DMA word available |
| dma_ack | input | 1 | Clocked DMA acknowledge / operation window |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| dma_data | output | 16 | DMA word |

## Verification
The hardest state to reach from the ports is the length limit. A full 2048 bytes must move within one acknowledge window before `sa_ready` or `dma_req` drops. In DMA mode, bytes must be left in the source at that moment, so the bench can show they are held back and then released as correctly paired and padded words. The bench preloads slightly more than the limit and keeps the acknowledge high through all edges. It then shows that the excess stays queued, closes and reopens the window, and collects the remainder. A behavioural model of the ready line, with its own operation counter, is compared on every clock.

// File: rtl/av_stream_out.sv
module av_stream_out #(
  parameter int MAX_BYTES = 2048,
  parameter int HALF_FAST = 4,
  parameter int HALF_SLOW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_dma,
  input  logic [1:0]  sa_clk_mode,
  input  logic        sa_clk_slow,
  input  logic        dma_two_cycle,
  input  logic        dma_big_endian,
  input  logic        src_valid,
  input  logic [7:0]  src_data,
  output logic        src_ready,
  input  logic        sa_clk_in,
  output logic        sa_clk_out,
  output logic [7:0]  sa_data,
  output logic        sa_ready,
  input  logic        sa_ack,
  input  logic        dma_clk_in,
  output logic        dma_req,
  input  logic        dma_ack,
  input  logic        host_cs_n,
  input  logic        host_rd_n,
  output logic [15:0] dma_data
);
  localparam int CNTW = $clog2(MAX_BYTES + 1);
  localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int DIVW = $clog2(HMAX) + 1;
  localparam logic [CNTW-1:0] LIMIT = CNTW'(MAX_BYTES);

  logic            sclk_q, dclk_q, rd_q, clk_o;
  logic [DIVW-1:0] div_cnt;
  logic [CNTW-1:0] cnt;
  logic            hold_v;
  logic [7:0]      hold_b;
  logic            wd_v, wd_two;
  logic [7:0]      wd_b0, wd_b1;

  wire             int_mode = sa_clk_mode[1];
  wire [DIVW-1:0]  half_m1  = sa_clk_slow ? DIVW'(HALF_SLOW - 1) : DIVW'(HALF_FAST - 1);
  wire             tick     = int_mode && (div_cnt >= half_m1);
  wire             sa_evt   = int_mode ? (tick & clk_o)
                            : sa_clk_mode[0] ? (sclk_q & ~sa_clk_in) : (~sclk_q & sa_clk_in);
  wire             below    = cnt < LIMIT;
  wire             sa_xfer  = sa_evt & sa_ready & sa_ack;
  wire             dma_evt  = dma_two_cycle ? (~host_cs_n & host_rd_n & ~rd_q)
                                            : (dma_ack & dma_clk_in & ~dclk_q);
  wire             dma_xfer = dma_evt & dma_req;
  wire             session  = fmt_dma ? (dma_two_cycle ? ~host_cs_n : dma_ack) : sa_ack;
  wire [CNTW-1:0]  room     = LIMIT - cnt;
  wire             pack_idle  = fmt_dma & ~wd_v;
  wire             take_first = pack_idle & ~hold_v & src_valid & (room != '0);
  wire             make_pair  = pack_idle & hold_v & src_valid & (room >= CNTW'(2));
  wire             make_pad   = pack_idle & hold_v & (room != '0) & ~make_pair;
  wire [1:0]       moved    = sa_xfer ? 2'd1 : dma_xfer ? (wd_two ? 2'd2 : 2'd1) : 2'd0;

  assign sa_ready   = ~fmt_dma & src_valid & below;
  assign dma_req    = fmt_dma & wd_v & below;
  assign src_ready  = fmt_dma ? (take_first | make_pair) : sa_xfer;
  assign sa_data    = fmt_dma ? '0 : src_data;
  assign sa_clk_out = clk_o;
  assign dma_data   = (fmt_dma & wd_v) ? (dma_big_endian ? {wd_b0, wd_b1} : {wd_b1, wd_b0}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      dclk_q  <= 1'b0;
      rd_q    <= 1'b1;
      clk_o   <= 1'b0;
      div_cnt <= '0;
      cnt     <= '0;
      hold_v  <= 1'b0;
      hold_b  <= '0;
      wd_v    <= 1'b0;
      wd_two  <= 1'b0;
      wd_b0   <= '0;
      wd_b1   <= '0;
    end else begin
      sclk_q <= sa_clk_in;
      dclk_q <= dma_clk_in;
      rd_q   <= host_rd_n;

      if (!int_mode) begin
        div_cnt <= '0;
        clk_o   <= 1'b0;
      end else if (tick) begin
        div_cnt <= '0;
        clk_o   <= ~clk_o;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end

      if (!session) cnt <= '0;
      else          cnt <= cnt + CNTW'(moved);

      if (take_first) begin
        hold_v <= 1'b1;
        hold_b <= src_data;
      end else if (make_pair | make_pad) begin
        hold_v <= 1'b0;
      end

      if (make_pair | make_pad) begin
        wd_v   <= 1'b1;
        wd_two <= make_pair;
        wd_b0  <= hold_b;
        wd_b1  <= make_pair ? src_data : 8'h00;
      end else if (dma_xfer) begin
        wd_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/av_stream_out_chk.sv
module av_stream_out_chk #(
  parameter int CNTW      = 12,
  parameter int MAX_BYTES = 2048
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fmt_dma,
  input logic [1:0]      sa_clk_mode,
  input logic            sa_clk_out,
  input logic            sa_ready,
  input logic            sa_ack,
  input logic            src_ready,
  input logic            src_valid,
  input logic            dma_req,
  input logic            dma_big_endian,
  input logic [15:0]     dma_data,
  input logic [CNTW-1:0] cnt
);
  p_fmt_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sa_ready && dma_req));

  p_ready_has_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sa_ready |-> src_valid);

  p_pop_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !fmt_dma) |-> (sa_ready && sa_ack));

  p_ext_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sa_clk_mode[1]) |-> !sa_clk_out);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_BYTES);

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && $past(dma_req) && $stable(dma_big_endian)) |-> $stable(dma_data));
endmodule

bind av_stream_out av_stream_out_chk #(.CNTW(CNTW), .MAX_BYTES(MAX_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .fmt_dma(fmt_dma), .sa_clk_mode(sa_clk_mode),
  .sa_clk_out(sa_clk_out), .sa_ready(sa_ready), .sa_ack(sa_ack),
  .src_ready(src_ready), .src_valid(src_valid), .dma_req(dma_req),
  .dma_big_endian(dma_big_endian), .dma_data(dma_data), .cnt(cnt)
);

// File: tb/av_stream_out_tb_top.sv
`timescale 1ns/100ps
module av_stream_out_tb_top;
  localparam int MAXB = 2048;
  localparam int HF = 4;
  localparam int HS = 8;

  logic clk = 0, rst_n = 0;
  logic fmt_dma = 0, sa_clk_slow = 0, dma_two_cycle = 0, dma_big_endian = 1;
  logic [1:0] sa_clk_mode = 0;
  logic src_valid = 0, src_ready;
  logic [7:0] src_data = 0, sa_data;
  logic sa_clk_in = 0, sa_clk_out, sa_ready, sa_ack = 0;
  logic dma_clk_in = 0, dma_req, dma_ack = 0, host_cs_n = 1, host_rd_n = 1;
  logic [15:0] dma_data;

  av_stream_out #(.MAX_BYTES(MAXB), .HALF_FAST(HF), .HALF_SLOW(HS)) dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_dma(fmt_dma), .sa_clk_mode(sa_clk_mode),
    .sa_clk_slow(sa_clk_slow), .dma_two_cycle(dma_two_cycle), .dma_big_endian(dma_big_endian),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .sa_clk_in(sa_clk_in), .sa_clk_out(sa_clk_out), .sa_data(sa_data), .sa_ready(sa_ready),
    .sa_ack(sa_ack), .dma_clk_in(dma_clk_in), .dma_req(dma_req), .dma_ack(dma_ack),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .dma_data(dma_data));

  always #2.5 clk = ~clk;

  logic [7:0]  srcq[$];
  logic [7:0]  expb[$];
  logic [15:0] expw[$];
  int checks = 0, errors = 0;
  int mcnt = 0, got_b = 0, got_w = 0, hi_run = 0, last_hi = 0;
  bit pend_pop = 0, finished = 0;
  bit sclk_prev = 0, out_prev = 0, dclk_prev = 0, rd_prev = 1;
  string wtag = "R6";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refresh();
    src_valid = srcq.size() > 0;
    src_data  = (srcq.size() > 0) ? srcq[0] : 8'h00;
  endtask

  always @(posedge clk) begin
    #0.5;
    if (pend_pop && srcq.size() > 0) void'(srcq.pop_front());
    pend_pop = 0;
    refresh();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit sedge, dedge;
      pend_pop = src_ready && src_valid;
      if (!fmt_dma) begin
        chk(sa_ready == (src_valid && mcnt < MAXB), "R2 ready model", sa_ready, src_valid && mcnt < MAXB);
        chk(dma_req == 0 && dma_data == 0, "R1 dma idle", dma_req, 0);
      end else begin
        chk(sa_ready == 0 && sa_data == 0, "R1 port idle", sa_ready, 0);
      end
      if (sa_clk_mode[1]) sedge = sa_clk_out && !out_prev;
      else if (sa_clk_mode[0]) sedge = !sa_clk_in && sclk_prev;
      else sedge = sa_clk_in && !sclk_prev;
      if (!sa_clk_mode[1]) chk(sa_clk_out == 0, "R4 ext clk out low", sa_clk_out, 0);
      if (!fmt_dma && sedge && sa_ready && sa_ack) begin
        if (expb.size() == 0) chk(0, "R3 unexpected byte", sa_data, -1);
        else chk(sa_data == expb[0], "R3 byte", sa_data, expb[0]);
        if (expb.size() > 0) void'(expb.pop_front());
        got_b++;
        mcnt++;
      end
      if (!sa_ack) mcnt = 0;
      dedge = dma_two_cycle ? (!host_cs_n && host_rd_n && !rd_prev)
                            : (dma_ack && dma_clk_in && !dclk_prev);
      if (fmt_dma && dedge && dma_req) begin
        if (expw.size() == 0) chk(0, {wtag, " unexpected word"}, dma_data, -1);
        else chk(dma_data == expw[0], {wtag, " word"}, dma_data, expw[0]);
        if (expw.size() > 0) void'(expw.pop_front());
        got_w++;
      end
      if (sa_clk_out) hi_run++;
      else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    end
    sclk_prev = sa_clk_in; out_prev = sa_clk_out; dclk_prev = dma_clk_in; rd_prev = host_rd_n;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(2);
    chk(sa_ready == 0 && dma_req == 0 && src_ready == 0, "R10 reset outputs", sa_ready + dma_req + src_ready, 0);
    chk(sa_clk_out == 0 && dma_data == 0, "R10 reset clk/data", dma_data, 0);
    srcq.delete(); expb.delete(); expw.delete();
    refresh();
    mcnt = 0; got_b = 0; got_w = 0;
    rst_n = 1;
    tick(2);
  endtask

  task automatic push_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'((i * 37 + seed) & 255);
      srcq.push_back(b);
      expb.push_back(b);
    end
    refresh();
  endtask

  task automatic push_words(input int n, input int seed, input bit big);
    logic [7:0] bs[$];
    for (int i = 0; i < n; i++) bs.push_back(8'((i * 53 + seed) & 255));
    for (int i = 0; i < n; i += 2) begin
      logic [7:0] a = bs[i];
      logic [7:0] b = (i + 1 < n) ? bs[i + 1] : 8'h00;
      expw.push_back(big ? {a, b} : {b, a});
    end
    for (int i = 0; i < n; i++) srcq.push_back(bs[i]);
    refresh();
  endtask

  task automatic sclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin sa_clk_in = 1; tick(3); sa_clk_in = 0; tick(3); end
  endtask
  task automatic dclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin dma_clk_in = 1; tick(4); dma_clk_in = 0; tick(4); end
  endtask
  task automatic rd_pulses(input int n);
    for (int i = 0; i < n; i++) begin host_rd_n = 0; tick(4); host_rd_n = 1; tick(4); end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    do_reset();

    // R3: rising external edges
    sa_ack = 1; push_bytes(20, 5);
    sclk_pulses(20); tick(2);
    chk(got_b == 20 && expb.size() == 0, "R3 rising count", got_b, 20);

    // R3: acknowledge low gates transfers
    sa_ack = 0; push_bytes(4, 90); tick(2);
    sclk_pulses(3); tick(2);
    chk(srcq.size() == 4, "R3 no move without ack", srcq.size(), 4);
    sa_ack = 1; sclk_pulses(4); tick(2);
    chk(got_b == 24 && srcq.size() == 0, "R3 after ack", got_b, 24);

    // R4: falling external edge active, rising edge ignored
    do_reset();
    sa_clk_mode = 1; sa_ack = 1; push_bytes(5, 11);
    sa_clk_in = 1; tick(4);
    chk(srcq.size() == 5, "R4 rising ignored in inverted", srcq.size(), 5);
    sa_clk_in = 0; tick(4);
    chk(srcq.size() == 4 && got_b == 1, "R4 falling moves", srcq.size(), 4);
    sclk_pulses(4); tick(2);
    chk(got_b == 5, "R4 inverted count", got_b, 5);

    // R4: internal clock fast and slow
    do_reset();
    sa_clk_mode = 2; sa_clk_slow = 0; sa_ack = 1; push_bytes(10, 33);
    tick(10 * 2 * HF + 20);
    chk(got_b == 10 && expb.size() == 0, "R4 internal fast count", got_b, 10);
    chk(last_hi == HF, "R4 fast phase", last_hi, HF);
    sa_clk_slow = 1; push_bytes(6, 71);
    tick(6 * 2 * HS + 40);
    chk(got_b == 16 && expb.size() == 0, "R4 internal slow count", got_b, 16);
    chk(last_hi == HS, "R4 slow phase", last_hi, HS);

    // R5: per-operation limit on the 8-bit port
    do_reset();
    sa_clk_mode = 0; sa_ack = 1; push_bytes(MAXB + 12, 7);
    sclk_pulses(MAXB + 12); tick(2);
    chk(got_b == MAXB, "R5 limit bytes", got_b, MAXB);
    chk(sa_ready == 0 && srcq.size() == 12, "R5 held back", srcq.size(), 12);
    sa_ack = 0; tick(2); sa_ack = 1; tick(1);
    sclk_pulses(12); tick(2);
    chk(got_b == MAXB + 12 && expb.size() == 0, "R5 resume", got_b, MAXB + 12);

    // R6/R8/R9: clocked DMA, big endian, odd count
    do_reset();
    sa_ack = 0; fmt_dma = 1; dma_two_cycle = 0; dma_big_endian = 1; dma_ack = 1;
    wtag = "R8"; push_words(9, 3, 1); tick(4);
    dclk_pulses(8); tick(2);
    chk(got_w == 5 && expw.size() == 0, "R6 clocked big count", got_w, 5);
    chk(srcq.size() == 0, "R9 odd byte drained", srcq.size(), 0);

    // R8: little endian, even count
    do_reset();
    fmt_dma = 1; dma_big_endian = 0; dma_ack = 1;
    wtag = "R8"; push_words(8, 19, 0); tick(4);
    dclk_pulses(6); tick(2);
    chk(got_w == 4 && expw.size() == 0, "R8 little count", got_w, 4);

    // R7/R9: strobed DMA, DMA clock ignored, odd little endian
    do_reset();
    fmt_dma = 1; dma_two_cycle = 1; dma_big_endian = 0; dma_ack = 1;
    wtag = "R9"; push_words(7, 41, 0); tick(4);
    dclk_pulses(3); tick(2);
    chk(got_w == 0 && dma_req == 1, "R7 dma clock ignored", got_w, 0);
    host_cs_n = 0; tick(1);
    rd_pulses(6); tick(2);
    chk(got_w == 4 && expw.size() == 0, "R7 strobed count", got_w, 4);
    host_cs_n = 1;

    // R5/R9: DMA limit with three bytes left over
    do_reset();
    fmt_dma = 1; dma_two_cycle = 0; dma_big_endian = 1; dma_ack = 1;
    wtag = "R5"; push_words(MAXB + 3, 9, 1); tick(4);
    dclk_pulses(MAXB / 2 + 4); tick(2);
    chk(got_w == MAXB / 2, "R5 dma limit words", got_w, MAXB / 2);
    chk(dma_req == 0, "R5 dma req held low", dma_req, 0);
    dma_ack = 0; tick(2); dma_ack = 1; tick(1);
    dclk_pulses(4); tick(2);
    chk(got_w == MAXB / 2 + 2 && expw.size() == 0, "R9 dma remainder padded", got_w, MAXB / 2 + 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule